// File: doc/BRIEF.md
# Windowed Retirement Event Threshold Monitor

The monitor watches a stream of retirement strobes, one set each clock cycle, and raises a trip when the event counts collected inside a programmable instruction window cross their thresholds. A window counter advances on one selected class of retired operation. When it reaches the programmed window size, the event counters restart. The block has a parameterised number of event counters (two by default). Each counter has its own enable, event-class select and 7-bit threshold. The counters are merged in either AND mode or OR mode.

Mispredicts can be counted in two ways. In the first they add up over the whole window. In the second only an unbroken run of mispredicts counts. Events in guest mode can be masked. On a trip the block produces a one-cycle pulse and a sticky flag. It can also raise a freeze request towards an external branch-record buffer. All configuration arrives as static levels from registers outside the block.

Top module: `evt_window_mon`

## Requirements
- R1: The window counter advances once per cycle in which the source chosen by `cfg_win_src` strobes (00 instruction, 01 branch, 10 return, 11 indirect branch). In the cycle after the count reaches `cfg_win_size`, every event counter restarts from zero.
- R2: An event that arrives in the cycle in which the counters restart is counted into the new window.
- R3: Each event counter counts the class chosen by its 2-bit select (00 mispredict, 01 branch, 10 return, 11 indirect branch). Counter 0 uses bits [1:0] and counter 1 uses bits [3:2]. A counter saturates at 255 and does not wrap.
- R4: Trips are evaluated only in cycles in which an instruction retires. A counter meets its threshold when its updated count is greater than or equal to the threshold. A threshold of 0 therefore trips on every retired instruction.
- R5: When `cfg_and_mode` is 1, a trip needs every enabled counter to meet its threshold. When it is 0, any one enabled counter that meets its threshold is enough.
- R6: A counter whose enable bit is clear can neither block a trip nor cause one. With no counter enabled, the block never trips.
- R7: When `cfg_mis_run` is 0, a counter that selects mispredicts adds them up across the window. When it is 1, that counter clears whenever a branch retires without a mispredict strobe.
- R8: `trip_pulse` is high for the cycle after each qualifying instruction. `trip_sticky` sets on a trip and stays set until `trip_clr` is high. A trip in the same cycle as `trip_clr` leaves the flag set.
- R9: When `cfg_freeze_en` is 1, a trip sets `freeze_req`, which is cleared by `trip_clr`. When `cfg_freeze_en` is 0, `freeze_req` stays low.
- R10: When `cfg_guest_dis` is 1 and `guest_mode` is high, all strobes are ignored: nothing counts, the window does not advance and no trip occurs.
- R11: While `cfg_enable` is low, the window counter and all event counters are held at zero and no trip occurs.
- R12: After reset, `trip_pulse`, `trip_sticky` and `freeze_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Global enable of the monitor |
| cfg_guest_dis | input | 1 | Ignore events while guest_mode is high |
| cfg_freeze_en | input | 1 | Let a trip raise freeze_req |
| cfg_and_mode | input | 1 | 1: all enabled counters needed; 0: any one |
| cfg_mis_run | input | 1 | 1: mispredicts count as an unbroken run |
| cfg_win_src | input | 2 | Event class that advances the window |
| cfg_win_size | input | 10 | Window length in source events (0 to 1023) |
| cfg_cnt_en | input | 2 | Per-counter enable |
| cfg_cnt_sel | input | 4 | Per-counter event class, 2 bits each |
| cfg_cnt_thr | input | 14 | Per-counter threshold, 7 bits each |
| ev_inst | input | 1 | Instruction retired |
| ev_branch | input | 1 | Branch retired |
| ev_return | input | 1 | Return retired |
| ev_indirect | input | 1 | Indirect branch retired |
| ev_mispred | input | 1 | Retired branch was mispredicted |
| guest_mode | input | 1 | Core runs in guest (non-root) mode |
| trip_clr | input | 1 | Write-one-to-clear for the sticky flag and the freeze request |
| trip_pulse | output | 1 | One-cycle trip indication |
| trip_sticky | output | 1 | Sticky trip flag |
| freeze_req | output | 1 | Freeze request to the branch-record buffer |

## Verification
The bench targets the window boundary. It closes a short window and checks that the count collected before the boundary is gone. It also checks that an event landing in the restart cycle survives; a design that drops it misses a trip. Each window source is checked against strobes of the other classes, so a window wired to the wrong source closes early or never. In the combine tests, a disabled counter is given a threshold that would block or force a trip if it took part. The bench also checks the run-mode clear on a correct branch, guest masking, a counter held during global disable, and saturation past 255. A counter that wraps there would read a small value and stay silent.

// File: rtl/evwm_pkg.sv
package evwm_pkg;

    typedef struct packed {
        logic inst;
        logic br;
        logic ret;
        logic ind;
        logic mis;
    } evwm_ev_t;

    typedef enum logic [1:0] {
        SRC_INST = 2'b00,
        SRC_BR   = 2'b01,
        SRC_RET  = 2'b10,
        SRC_IND  = 2'b11
    } evwm_win_src_e;

    typedef enum logic [1:0] {
        CSEL_MIS = 2'b00,
        CSEL_BR  = 2'b01,
        CSEL_RET = 2'b10,
        CSEL_IND = 2'b11
    } evwm_cnt_sel_e;

    // strobe that advances the window for a given source code
    function automatic logic win_pick(input logic [1:0] src, input evwm_ev_t ev);
        logic r;
        case (evwm_win_src_e'(src))
            SRC_INST: r = ev.inst;
            SRC_BR:   r = ev.br;
            SRC_RET:  r = ev.ret;
            default:  r = ev.ind;
        endcase
        return r;
    endfunction

    // strobe that an event counter takes for a given select code
    function automatic logic cnt_pick(input logic [1:0] sel, input evwm_ev_t ev);
        logic r;
        case (evwm_cnt_sel_e'(sel))
            CSEL_MIS: r = ev.mis;
            CSEL_BR:  r = ev.br;
            CSEL_RET: r = ev.ret;
            default:  r = ev.ind;
        endcase
        return r;
    endfunction

    // a branch retired with a correct prediction
    function automatic logic good_branch(input evwm_ev_t ev);
        return ev.br & ~ev.mis;
    endfunction

endpackage

// File: rtl/evwm_window.sv
module evwm_window
    import evwm_pkg::*;
#(
    parameter int WIN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             active,
    input  logic [1:0]       src,
    input  logic [WIN_W-1:0] size,
    input  evwm_ev_t         ev,
    output logic             win_clr
);
    localparam int SUM_W = WIN_W + 1;

    typedef struct packed {
        logic [WIN_W-1:0] cnt;
        logic             wrap;
    } win_st_t;

    win_st_t          s_q, s_d;
    logic             tick;
    logic [SUM_W-1:0] base, inc;

    always_comb begin
        tick = active & win_pick(src, ev);
        base = s_q.wrap ? '0 : {1'b0, s_q.cnt};
        inc  = base + SUM_W'(tick);
        s_d  = s_q;
        if (!enable) begin
            s_d = '0;
        end else begin
            s_d.cnt  = inc[WIN_W] ? '1 : inc[WIN_W-1:0];
            s_d.wrap = (inc >= {1'b0, size});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign win_clr = s_q.wrap;

endmodule

// File: rtl/evwm_counter.sv
module evwm_counter
    import evwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int THR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             active,
    input  logic             win_clr,
    input  logic             run_mode,
    input  logic [1:0]       sel,
    input  logic [THR_W-1:0] thr,
    input  evwm_ev_t         ev,
    output logic             met_d,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q, cnt_d, base;
    logic             hit, run_break;

    always_comb begin
        hit       = active & cnt_pick(sel, ev);
        run_break = active & run_mode & (sel == CSEL_MIS) & good_branch(ev);
        base      = win_clr ? '0 : cnt_q;
        if (!enable)                    cnt_d = '0;
        else if (run_break)             cnt_d = '0;
        else if (hit && base != CNT_MAX) cnt_d = base + 1'b1;
        else                            cnt_d = base;
        met_d = (cnt_d >= CNT_W'(thr));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/evwm_trip.sv
module evwm_trip #(
    parameter int NCNT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCNT-1:0] en,
    input  logic [NCNT-1:0] met,
    input  logic            and_mode,
    input  logic            qualify,
    input  logic            freeze_en,
    input  logic            clr,
    output logic            pulse,
    output logic            sticky,
    output logic            freeze
);
    typedef struct packed {
        logic pulse;
        logic sticky;
        logic freeze;
    } trip_st_t;

    trip_st_t s_q, s_d;
    logic     any_en, all_ok, any_ok, fire;

    always_comb begin
        any_en = |en;
        all_ok = &(~en | met);
        any_ok = |(en & met);
        fire   = qualify & (and_mode ? (any_en & all_ok) : any_ok);
        s_d.pulse  = fire;
        s_d.sticky = fire | (s_q.sticky & ~clr);
        s_d.freeze = (fire & freeze_en) | (s_q.freeze & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse  = s_q.pulse;
    assign sticky = s_q.sticky;
    assign freeze = s_q.freeze;

endmodule

// File: rtl/evt_window_mon.sv
module evt_window_mon
    import evwm_pkg::*;
#(
    parameter int NCNT  = 2,
    parameter int WIN_W = 10,
    parameter int THR_W = 7,
    parameter int CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_enable,
    input  logic                  cfg_guest_dis,
    input  logic                  cfg_freeze_en,
    input  logic                  cfg_and_mode,
    input  logic                  cfg_mis_run,
    input  logic [1:0]            cfg_win_src,
    input  logic [WIN_W-1:0]      cfg_win_size,
    input  logic [NCNT-1:0]       cfg_cnt_en,
    input  logic [2*NCNT-1:0]     cfg_cnt_sel,
    input  logic [THR_W*NCNT-1:0] cfg_cnt_thr,
    input  logic                  ev_inst,
    input  logic                  ev_branch,
    input  logic                  ev_return,
    input  logic                  ev_indirect,
    input  logic                  ev_mispred,
    input  logic                  guest_mode,
    input  logic                  trip_clr,
    output logic                  trip_pulse,
    output logic                  trip_sticky,
    output logic                  freeze_req
);
    evwm_ev_t              ev;
    logic                  active, qualify, win_clr;
    logic [NCNT-1:0]       met;
    logic [NCNT*CNT_W-1:0] cnt_flat;

    always_comb begin
        ev      = '{inst: ev_inst, br: ev_branch, ret: ev_return,
                    ind: ev_indirect, mis: ev_mispred};
        active  = cfg_enable & ~(cfg_guest_dis & guest_mode);
        qualify = active & ev_inst;
    end

    evwm_window #(.WIN_W(WIN_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (cfg_enable),
        .active  (active),
        .src     (cfg_win_src),
        .size    (cfg_win_size),
        .ev      (ev),
        .win_clr (win_clr)
    );

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        evwm_counter #(.CNT_W(CNT_W), .THR_W(THR_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (cfg_enable & cfg_cnt_en[g]),
            .active   (active),
            .win_clr  (win_clr),
            .run_mode (cfg_mis_run),
            .sel      (cfg_cnt_sel[2*g +: 2]),
            .thr      (cfg_cnt_thr[THR_W*g +: THR_W]),
            .ev       (ev),
            .met_d    (met[g]),
            .cnt      (cnt_flat[CNT_W*g +: CNT_W])
        );
    end

    evwm_trip #(.NCNT(NCNT)) u_trip (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_cnt_en),
        .met       (met),
        .and_mode  (cfg_and_mode),
        .qualify   (qualify),
        .freeze_en (cfg_freeze_en),
        .clr       (trip_clr),
        .pulse     (trip_pulse),
        .sticky    (trip_sticky),
        .freeze    (freeze_req)
    );

endmodule

// File: rtl/evwm_chk.sv
module evwm_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_enable,
    input logic          cfg_guest_dis,
    input logic          cfg_freeze_en,
    input logic          guest_mode,
    input logic          ev_inst,
    input logic          trip_clr,
    input logic          trip_pulse,
    input logic          trip_sticky,
    input logic          freeze_req,
    input logic [CW-1:0] cnt_flat
);
    AST_PULSE_NEEDS_INST: assert property (@(posedge clk) disable iff (!rst_n)
        trip_pulse |-> $past(ev_inst && cfg_enable)); // R4

    AST_GUEST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_guest_dis && guest_mode) |=> !trip_pulse); // R10

    AST_OFF_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (cnt_flat == '0) && !trip_pulse); // R11

    AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_sticky && !trip_clr) |=> trip_sticky); // R8

    AST_PULSE_IN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        trip_pulse |-> trip_sticky); // R8

    AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_freeze_en && !freeze_req) |=> !freeze_req); // R9

endmodule

bind evt_window_mon evwm_chk #(.CW(NCNT*CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_enable    (cfg_enable),
    .cfg_guest_dis (cfg_guest_dis),
    .cfg_freeze_en (cfg_freeze_en),
    .guest_mode    (guest_mode),
    .ev_inst       (ev_inst),
    .trip_clr      (trip_clr),
    .trip_pulse    (trip_pulse),
    .trip_sticky   (trip_sticky),
    .freeze_req    (freeze_req),
    .cnt_flat      (cnt_flat)
);

// File: tb/evt_window_mon_tb.sv
module evt_window_mon_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable, cfg_guest_dis, cfg_freeze_en, cfg_and_mode, cfg_mis_run;
    logic [1:0]  cfg_win_src;
    logic [9:0]  cfg_win_size;
    logic [1:0]  cfg_cnt_en;
    logic [3:0]  cfg_cnt_sel;
    logic [13:0] cfg_cnt_thr;
    logic ev_inst, ev_branch, ev_return, ev_indirect, ev_mispred;
    logic guest_mode, trip_clr;
    logic trip_pulse, trip_sticky, freeze_req;

    int nchk = 0;
    int nfail = 0;

    localparam logic [4:0] E_0 = 5'b00000;
    localparam logic [4:0] E_I = 5'b10000;
    localparam logic [4:0] E_B = 5'b01000;
    localparam logic [4:0] E_R = 5'b00100;
    localparam logic [4:0] E_N = 5'b00010;
    localparam logic [4:0] E_M = 5'b00001;

    // {inst, branch, return, indirect, mispred, expected trip_pulse}
    // counter 0 counts branches, threshold 3
    localparam logic [5:0] VEC [8] = '{
        6'b11000_0, 6'b11000_0, 6'b10000_0, 6'b11000_1,
        6'b10000_1, 6'b01000_0, 6'b10000_1, 6'b00000_0
    };

    always #5 clk = ~clk;

    evt_window_mon u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .cfg_guest_dis(cfg_guest_dis), .cfg_freeze_en(cfg_freeze_en),
        .cfg_and_mode(cfg_and_mode), .cfg_mis_run(cfg_mis_run),
        .cfg_win_src(cfg_win_src), .cfg_win_size(cfg_win_size),
        .cfg_cnt_en(cfg_cnt_en), .cfg_cnt_sel(cfg_cnt_sel), .cfg_cnt_thr(cfg_cnt_thr),
        .ev_inst(ev_inst), .ev_branch(ev_branch), .ev_return(ev_return),
        .ev_indirect(ev_indirect), .ev_mispred(ev_mispred),
        .guest_mode(guest_mode), .trip_clr(trip_clr),
        .trip_pulse(trip_pulse), .trip_sticky(trip_sticky), .freeze_req(freeze_req)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [4:0] e);
        {ev_inst, ev_branch, ev_return, ev_indirect, ev_mispred} = e;
        @(posedge clk);
        #2;
    endtask

    // reset and default configuration: counter 0 on branches, thresholds 127
    task automatic restart();
        rst_n = 1'b0;
        {ev_inst, ev_branch, ev_return, ev_indirect, ev_mispred} = E_0;
        trip_clr = 1'b0; guest_mode = 1'b0;
        cfg_enable = 1'b1; cfg_guest_dis = 1'b0; cfg_freeze_en = 1'b0;
        cfg_and_mode = 1'b0; cfg_mis_run = 1'b0;
        cfg_win_src = 2'b00; cfg_win_size = 10'd1023;
        cfg_cnt_en = 2'b01; cfg_cnt_sel = 4'b0101; cfg_cnt_thr = {7'd127, 7'd127};
        repeat (2) @(posedge clk);
        #2;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        restart();
        chk("R12 pulse", trip_pulse, 1'b0);
        chk("R12 sticky", trip_sticky, 1'b0);
        chk("R12 freeze", freeze_req, 1'b0);

        // vector table: threshold 3 on branches, trips only with an instruction
        cfg_cnt_thr = {7'd127, 7'd3};
        for (int i = 0; i < 8; i++) begin
            cyc(VEC[i][5:1]);
            chk($sformatf("R4 vector %0d", i), trip_pulse, VEC[i][0]);
        end
        chk("R8 sticky after trips", trip_sticky, 1'b1);
        cyc(E_0);
        chk("R8 sticky holds", trip_sticky, 1'b1);
        chk("R8 pulse one cycle", trip_pulse, 1'b0);
        trip_clr = 1'b1; cyc(E_0); trip_clr = 1'b0;
        chk("R8 sticky cleared", trip_sticky, 1'b0);
        cfg_cnt_thr = {7'd127, 7'd0};
        trip_clr = 1'b1; cyc(E_I); trip_clr = 1'b0;
        chk("R8 set wins over clear", trip_sticky, 1'b1);
        restart();
        chk("R12 sticky after reset", trip_sticky, 1'b0);

        // R1: window of 3 instructions clears the count
        restart(); cfg_win_size = 10'd3; cfg_cnt_thr = {7'd127, 7'd3};
        cyc(E_I | E_B); cyc(E_I | E_B); cyc(E_I);
        cyc(E_I | E_B);
        chk("R1 window clears counters", trip_pulse, 1'b0);

        // R2: event in the restart cycle counts
        restart(); cfg_win_size = 10'd3; cfg_cnt_thr = {7'd127, 7'd1};
        cyc(E_I); cyc(E_I); cyc(E_I);
        cyc(E_I | E_B);
        chk("R2 event in clear cycle", trip_pulse, 1'b1);

        // R1: window source = branches, counter counts returns
        restart(); cfg_win_src = 2'b01; cfg_win_size = 10'd1;
        cfg_cnt_sel = 4'b0110; cfg_cnt_thr = {7'd127, 7'd2};
        cyc(E_I | E_R); cyc(E_I | E_R);
        chk("R1 src branch", trip_pulse, 1'b1);

        // R1: window source = indirect
        restart(); cfg_win_src = 2'b11; cfg_win_size = 10'd1; cfg_cnt_thr = {7'd127, 7'd2};
        cyc(E_I | E_B | E_R); cyc(E_I | E_B | E_R);
        chk("R1 src indirect no tick", trip_pulse, 1'b1);
        cyc(E_I | E_N);
        chk("R1 src indirect tick", trip_pulse, 1'b1);
        cyc(E_I);
        chk("R1 src indirect cleared", trip_pulse, 1'b0);

        // R1: window source = return
        restart(); cfg_win_src = 2'b10; cfg_win_size = 10'd1; cfg_cnt_thr = {7'd127, 7'd2};
        cyc(E_I | E_B | E_N); cyc(E_I | E_B | E_N);
        chk("R1 src return no tick", trip_pulse, 1'b1);
        cyc(E_I | E_R);
        cyc(E_I);
        chk("R1 src return cleared", trip_pulse, 1'b0);

        // R3: indirect selection and saturation
        restart(); cfg_cnt_sel = 4'b0111; cfg_cnt_thr = {7'd127, 7'd1};
        cyc(E_I | E_B | E_R);
        chk("R3 indirect ignores others", trip_pulse, 1'b0);
        cyc(E_I | E_N);
        chk("R3 indirect counted", trip_pulse, 1'b1);
        restart(); cfg_win_src = 2'b11;
        repeat (300) cyc(E_B);
        cyc(E_I);
        chk("R3 saturates not wraps", trip_pulse, 1'b1);

        // R4: threshold 0
        restart(); cfg_cnt_thr = {7'd127, 7'd0};
        cyc(E_I); chk("R4 thr0 inst", trip_pulse, 1'b1);
        cyc(E_0); chk("R4 thr0 idle", trip_pulse, 1'b0);
        cyc(E_I); chk("R4 thr0 inst again", trip_pulse, 1'b1);

        // R5: AND / OR combine
        restart(); cfg_cnt_en = 2'b11; cfg_cnt_sel = 4'b1001;
        cfg_cnt_thr = {7'd1, 7'd1}; cfg_and_mode = 1'b1;
        cyc(E_I | E_B); chk("R5 and one met", trip_pulse, 1'b0);
        cyc(E_I | E_R); chk("R5 and both met", trip_pulse, 1'b1);
        restart(); cfg_cnt_en = 2'b11; cfg_cnt_sel = 4'b1001;
        cfg_cnt_thr = {7'd1, 7'd1}; cfg_and_mode = 1'b0;
        cyc(E_I | E_B); chk("R5 or one met", trip_pulse, 1'b1);

        // R6: disabled counter
        restart(); cfg_and_mode = 1'b1; cfg_cnt_thr = {7'd127, 7'd1};
        cyc(E_I | E_B); chk("R6 disabled does not block", trip_pulse, 1'b1);
        restart(); cfg_cnt_thr = {7'd0, 7'd127};
        cyc(E_I); chk("R6 disabled does not cause", trip_pulse, 1'b0);
        restart(); cfg_cnt_en = 2'b00; cfg_cnt_thr = {7'd0, 7'd0}; cfg_and_mode = 1'b1;
        cyc(E_I); chk("R6 none enabled and", trip_pulse, 1'b0);
        cfg_and_mode = 1'b0;
        cyc(E_I); chk("R6 none enabled or", trip_pulse, 1'b0);

        // R7: mispredict modes
        restart(); cfg_cnt_sel = 4'b0100; cfg_cnt_thr = {7'd127, 7'd2};
        cyc(E_B | E_M); cyc(E_B); cyc(E_I | E_B | E_M);
        chk("R7 window accumulate", trip_pulse, 1'b1);
        restart(); cfg_cnt_sel = 4'b0100; cfg_cnt_thr = {7'd127, 7'd2}; cfg_mis_run = 1'b1;
        cyc(E_B | E_M); cyc(E_B); cyc(E_I | E_B | E_M);
        chk("R7 run broken", trip_pulse, 1'b0);
        cyc(E_I | E_B | E_M);
        chk("R7 run of two", trip_pulse, 1'b1);

        // R9: freeze request
        restart(); cfg_cnt_thr = {7'd127, 7'd0};
        cyc(E_I);
        chk("R9 trip without freeze", trip_pulse, 1'b1);
        chk("R9 freeze off", freeze_req, 1'b0);
        restart(); cfg_cnt_thr = {7'd127, 7'd0}; cfg_freeze_en = 1'b1;
        cyc(E_I); chk("R9 freeze set", freeze_req, 1'b1);
        cyc(E_0); chk("R9 freeze holds", freeze_req, 1'b1);
        trip_clr = 1'b1; cyc(E_0); trip_clr = 1'b0;
        chk("R9 freeze cleared", freeze_req, 1'b0);

        // R10: guest masking
        restart(); cfg_guest_dis = 1'b1; guest_mode = 1'b1; cfg_cnt_thr = {7'd127, 7'd0};
        cyc(E_I); chk("R10 guest no trip", trip_pulse, 1'b0);
        cfg_cnt_thr = {7'd127, 7'd1};
        cyc(E_I | E_B); cyc(E_I | E_B);
        chk("R10 guest no count trip", trip_pulse, 1'b0);
        guest_mode = 1'b0;
        cyc(E_I); chk("R10 guest events not counted", trip_pulse, 1'b0);
        cfg_guest_dis = 1'b0; guest_mode = 1'b1;
        cyc(E_I | E_B); chk("R10 guest allowed", trip_pulse, 1'b1);

        // R11: global enable
        restart(); cfg_enable = 1'b0; cfg_cnt_thr = {7'd127, 7'd0};
        cyc(E_I); chk("R11 disabled no trip", trip_pulse, 1'b0);
        cfg_cnt_thr = {7'd127, 7'd1};
        cyc(E_B); cyc(E_B); cyc(E_B);
        cfg_enable = 1'b1;
        cyc(E_I); chk("R11 counts held zero", trip_pulse, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule